// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the eight-bit status register of an asynchronous serial port. It sits between the CPU bus and the transmit and receive datapaths. Hardware events from the transmitter and receiver set its flags, and the CPU reads the register to see the port's state. A flag that can be cleared takes a two-step handshake: the CPU must first read the flag as 1 and then write 0 to it. A CPU write can never set a flag.

The block also owns the receive data buffer. It loads a character from the receiver only when that character arrived without error and the buffer is empty. A character that completes while the buffer is still full raises the overrun flag and is dropped, so the data already buffered is never lost. Standby entry puts the flags back to their initial values but keeps the buffer.

Top module: `sport_status_reg`

## Requirements
- R1: After an asynchronous reset, with `tx_idle_i` low, `rd_data_o` reads 0x80 and `rx_data_o` reads 0. Bit map: 7 transmit-empty, 6 receive-full, 5 overrun, 4 framing error, 3 parity error, 2 transmit-end, 1 received multiprocessor bit, 0 multiprocessor-transfer control.
- R2: A CPU write with 1 in any of bits 7..3 never sets that flag.
- R3: A CPU write of 0 to a flag in bits 7..3 leaves the flag unchanged unless a bus read returned that flag as 1 after it was last set.
- R4: A bus read that returns a flag as 1 arms it. The next write of 0 to that flag clears it. Any write consumes the arming, including one that writes 1 to the bit, and a hardware set of the flag also cancels it.
- R5: Bit 2 always mirrors `tx_idle_i`. Bit 1 holds the multiprocessor bit of the last character loaded into the buffer. Writes change neither bit.
- R6: Transmit-empty (bit 7) is set on the edge after `tx_load_i` is high, and on every edge while `tx_enable_i` is low. Clearing it has no effect while the transmitter is disabled.
- R7: When `rx_done_i` is high with `rx_enable_i` high, no error pulse and receive-full clear, the next edge loads `rx_char_i` into `rx_data_o` and sets receive-full.
- R8: When `rx_done_i` comes with a parity or framing error pulse, the matching error flag is set, and neither receive-full nor `rx_data_o` changes. Lowering `rx_enable_i` also leaves both unchanged, and `rx_done_i` is then ignored.
- R9: When `rx_done_i` comes (receiver enabled) while receive-full is 1, the overrun flag is set and the buffer keeps its old character.
- R10: When a hardware set event and a qualifying CPU clear of the same flag fall in one cycle, the flag ends up 1.
- R11: A one-cycle `standby_i` sets transmit-empty and clears receive-full, overrun, framing and parity error. `rx_data_o` is kept.
- R12: Bit 0 is a plain read/write control bit with reset value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby entry; reinitialises the flags |
| rd_en_i | input | 1 | Bus read strobe for the register |
| wr_en_i | input | 1 | Bus write strobe for the register |
| wr_data_i | input | 8 | Bus write data |
| rd_data_o | output | 8 | Current register contents |
| tx_enable_i | input | 1 | Transmitter enable level |
| tx_load_i | input | 1 | Pulse: transmit buffer moved to the shifter |
| tx_idle_i | input | 1 | Transmit-end level from the transmitter |
| rx_enable_i | input | 1 | Receiver enable level |
| rx_done_i | input | 1 | Pulse: a received character is complete |
| rx_char_i | input | DATA_W | Character from the receive shifter |
| rx_mpb_i | input | 1 | Multiprocessor bit of the character |
| parity_err_i | input | 1 | Pulse: parity error detected |
| frame_err_i | input | 1 | Pulse: framing error detected |
| rx_data_o | output | DATA_W | Receive data buffer |

## Verification
If the arming state is wrong, the fault shows at `rd_data_o` on the cycle after a write. A flag that should have cleared stays at 1, or a flag that was never read drops to 0. A wrong receive-full or overrun decision shows one edge after `rx_done_i`: `rx_data_o` changes when it should hold, or bits 6 and 5 take the wrong values. The bench therefore reads the register and the buffer right after every event. It also places set and clear events in the same cycle, so that a wrong priority shows up as a flag with the wrong value.

// File: rtl/sport_status_pkg.sv
package sport_status_pkg;

  localparam int REG_W    = 8;
  localparam int NFLAG    = 5;
  localparam int FLAG_LSB = 3;

  localparam int B_TEND = 2;
  localparam int B_MPB  = 1;
  localparam int B_MPBT = 0;

  // flag vector index: 4 tx-empty, 3 rx-full, 2 overrun, 1 framing, 0 parity
  localparam int F_PER  = 0;
  localparam int F_FER  = 1;
  localparam int F_ORER = 2;
  localparam int F_RDRF = 3;
  localparam int F_TDRE = 4;

  localparam logic [NFLAG-1:0] FLAG_INIT = 5'b10000;

  function automatic logic f_accept(input logic en, input logic done,
                                    input logic perr, input logic ferr,
                                    input logic full);
    return en & done & ~perr & ~ferr & ~full;
  endfunction

  function automatic logic f_overrun(input logic en, input logic done,
                                     input logic full);
    return en & done & full;
  endfunction

  function automatic logic [REG_W-1:0] f_pack(input logic [NFLAG-1:0] flags,
                                              input logic tend,
                                              input logic mpb,
                                              input logic mpbt);
    logic [REG_W-1:0] r;
    r = '0;
    r[REG_W-1:FLAG_LSB] = flags;
    r[B_TEND] = tend;
    r[B_MPB]  = mpb;
    r[B_MPBT] = mpbt;
    return r;
  endfunction

endpackage

// File: rtl/ss_flag_cell.sv
module ss_flag_cell #(
  parameter logic INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic armed_o,
  output logic clr_o
);

  logic flag_q;
  logic armed_q;

  assign clr_o   = wr_i & ~wbit_i & armed_q;
  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= INIT_VAL;
      armed_q <= 1'b0;
    end else if (init_i) begin
      flag_q  <= INIT_VAL;
      armed_q <= 1'b0;
    end else begin
      if (set_i)      flag_q <= 1'b1;
      else if (clr_o) flag_q <= 1'b0;

      if (set_i || wr_i)        armed_q <= 1'b0;
      else if (rd_i && flag_q)  armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ss_event_decode.sv
module ss_event_decode
  import sport_status_pkg::*;
(
  input  logic             tx_enable_i,
  input  logic             tx_load_i,
  input  logic             rx_enable_i,
  input  logic             rx_done_i,
  input  logic             parity_err_i,
  input  logic             frame_err_i,
  input  logic             rx_full_i,
  output logic [NFLAG-1:0] set_vec_o,
  output logic             accept_o,
  output logic             overrun_o
);

  always_comb begin
    accept_o  = f_accept(rx_enable_i, rx_done_i, parity_err_i, frame_err_i, rx_full_i);
    overrun_o = f_overrun(rx_enable_i, rx_done_i, rx_full_i);
    set_vec_o         = '0;
    set_vec_o[F_TDRE] = ~tx_enable_i | tx_load_i;
    set_vec_o[F_RDRF] = accept_o;
    set_vec_o[F_ORER] = overrun_o;
    set_vec_o[F_FER]  = frame_err_i;
    set_vec_o[F_PER]  = parity_err_i;
  end

endmodule

// File: rtl/ss_rx_capture.sv
module ss_rx_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              mpb_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      mpb_o  <= 1'b0;
    end else if (accept_i) begin
      data_o <= char_i;
      mpb_o  <= mpb_i;
    end
  end

endmodule

// File: rtl/sport_status_reg.sv
module sport_status_reg
  import sport_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic              tx_enable_i,
  input  logic              tx_load_i,
  input  logic              tx_idle_i,
  input  logic              rx_enable_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_char_i,
  input  logic              rx_mpb_i,
  input  logic              parity_err_i,
  input  logic              frame_err_i,
  output logic [DATA_W-1:0] rx_data_o
);

  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] armed;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] set_vec;
  logic             accept_evt;
  logic             overrun_evt;
  logic             mpb;
  logic             mpbt_q;

  ss_event_decode u_dec (
    .tx_enable_i  (tx_enable_i),
    .tx_load_i    (tx_load_i),
    .rx_enable_i  (rx_enable_i),
    .rx_done_i    (rx_done_i),
    .parity_err_i (parity_err_i),
    .frame_err_i  (frame_err_i),
    .rx_full_i    (flags[F_RDRF]),
    .set_vec_o    (set_vec),
    .accept_o     (accept_evt),
    .overrun_o    (overrun_evt)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ss_flag_cell #(.INIT_VAL(FLAG_INIT[i])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (standby_i),
      .set_i   (set_vec[i]),
      .rd_i    (rd_en_i),
      .wr_i    (wr_en_i),
      .wbit_i  (wr_data_i[i+FLAG_LSB]),
      .flag_o  (flags[i]),
      .armed_o (armed[i]),
      .clr_o   (clr_vec[i])
    );
  end

  ss_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_evt),
    .char_i   (rx_char_i),
    .mpb_i    (rx_mpb_i),
    .data_o   (rx_data_o),
    .mpb_o    (mpb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mpbt_q <= 1'b0;
    else if (standby_i)  mpbt_q <= 1'b0;
    else if (wr_en_i)    mpbt_q <= wr_data_i[B_MPBT];
  end

  assign rd_data_o = f_pack(flags, tx_idle_i, mpb, mpbt_q);

endmodule

// File: rtl/sport_status_sva.sv
module sport_status_sva
  import sport_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_i,
  input logic              tx_enable_i,
  input logic              rx_done_i,
  input logic              parity_err_i,
  input logic              frame_err_i,
  input logic              wr_en_i,
  input logic [7:0]        wr_data_i,
  input logic [7:0]        rd_data_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  armed,
  input logic [NFLAG-1:0]  set_vec,
  input logic              accept_evt,
  input logic              overrun_evt,
  input logic              mpb
);

  a_r2_no_cpu_set: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(standby_i) |-> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

  a_r3_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(standby_i) |->
      ((~flags & $past(flags) &
        ~$past({NFLAG{wr_en_i}} & ~wr_data_i[REG_W-1:FLAG_LSB] & armed)) == '0));

  a_r4_hw_set_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((armed & $past(set_vec)) == '0));

  a_r5_mpb_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> $stable(mpb));

  a_r6_tdre_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable_i |=> rd_data_o[7]);

  a_r7_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !standby_i) |=> rd_data_o[6]);

  a_r8_error_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && (parity_err_i || frame_err_i)) |=> $stable(rx_data_o));

  a_r9_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !standby_i) |=> ($stable(rx_data_o) && rd_data_o[5]));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(standby_i) |-> (($past(set_vec) & ~flags) == '0));

endmodule

bind sport_status_reg sport_status_sva #(.DATA_W(DATA_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .standby_i    (standby_i),
  .tx_enable_i  (tx_enable_i),
  .rx_done_i    (rx_done_i),
  .parity_err_i (parity_err_i),
  .frame_err_i  (frame_err_i),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .rx_data_o    (rx_data_o),
  .flags        (flags),
  .armed        (armed),
  .set_vec      (set_vec),
  .accept_evt   (accept_evt),
  .overrun_evt  (overrun_evt),
  .mpb          (mpb)
);

// File: tb/sport_status_reg_tb.sv
`timescale 1ns/1ps
module sport_status_reg_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       tx_enable_i = 1'b0;
  logic       tx_load_i = 1'b0;
  logic       tx_idle_i = 1'b0;
  logic       rx_enable_i = 1'b1;
  logic       rx_done_i = 1'b0;
  logic [7:0] rx_char_i = '0;
  logic       rx_mpb_i = 1'b0;
  logic       parity_err_i = 1'b0;
  logic       frame_err_i = 1'b0;
  logic [7:0] rx_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sport_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .tx_enable_i(tx_enable_i), .tx_load_i(tx_load_i),
    .tx_idle_i(tx_idle_i), .rx_enable_i(rx_enable_i), .rx_done_i(rx_done_i),
    .rx_char_i(rx_char_i), .rx_mpb_i(rx_mpb_i), .parity_err_i(parity_err_i),
    .frame_err_i(frame_err_i), .rx_data_o(rx_data_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_read(output logic [7:0] d);
    rd_en_i = 1'b1;
    d = rd_data_o;
    step();
    rd_en_i = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic rx_char(input logic [7:0] c, input logic m, input logic pe, input logic fe);
    rx_done_i = 1'b1; rx_char_i = c; rx_mpb_i = m;
    parity_err_i = pe; frame_err_i = fe;
    step();
    rx_done_i = 1'b0; parity_err_i = 1'b0; frame_err_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset status", rd_data_o, 8'h80);
    chk("R1 reset buffer", rx_data_o, 8'h00);
    chk("R12 control bit resets 0", {7'd0, rd_data_o[0]}, 8'h00);
  endtask

  task automatic t_handshake();
    logic [7:0] d;
    bus_write(8'h7F);
    chk("R3 write 0 without read keeps TDRE", rd_data_o, 8'h81);
    chk("R12 control bit written", {7'd0, rd_data_o[0]}, 8'h01);
    bus_read(d);
    chk("R4 read value", d, 8'h81);
    bus_write(8'h00);
    chk("R4 read-1 then write-0 clears", rd_data_o, 8'h00);
    bus_write(8'hFF);
    chk("R2 write 1 never sets flags", rd_data_o, 8'h01);
    bus_write(8'h00);
    chk("R12 control bit cleared", rd_data_o, 8'h00);
  endtask

  task automatic t_arm_consumed();
    logic [7:0] d;
    tx_load_i = 1'b1; step(); tx_load_i = 1'b0;
    chk("R6 load sets TDRE", rd_data_o, 8'h80);
    bus_read(d);
    bus_write(8'hFF);
    bus_write(8'h7F);
    chk("R4 arming consumed by any write", rd_data_o, 8'h81);
    bus_read(d);
    bus_write(8'h00);
    chk("R4 re-armed clear", rd_data_o, 8'h00);
  endtask

  task automatic t_tx_disable();
    logic [7:0] d;
    tx_enable_i = 1'b0; step();
    chk("R6 disabled sets TDRE", rd_data_o, 8'h80);
    bus_read(d);
    bus_write(8'h00);
    chk("R6 clear ignored while disabled", rd_data_o, 8'h80);
    tx_enable_i = 1'b1; step();
    bus_read(d);
    bus_write(8'h00);
    chk("R6 clear after enable", rd_data_o, 8'h00);
  endtask

  task automatic t_rx_accept();
    rx_char(8'hA5, 1'b1, 1'b0, 1'b0);
    chk("R7 receive-full set", rd_data_o, 8'h42);
    chk("R7 buffer loaded", rx_data_o, 8'hA5);
    bus_write(8'hFF);
    chk("R5 MPB ignores write", rd_data_o, 8'h43);
    bus_write(8'h00);
    chk("R3 unarmed RDRF kept", rd_data_o, 8'h42);
    tx_idle_i = 1'b1; #1;
    chk("R5 TEND mirrors idle", rd_data_o, 8'h46);
    bus_write(8'h00);
    chk("R5 TEND ignores write", rd_data_o, 8'h46);
    tx_idle_i = 1'b0;
    rx_enable_i = 1'b0; step();
    chk("R8 rx disable keeps RDRF", rd_data_o, 8'h42);
    chk("R8 rx disable keeps buffer", rx_data_o, 8'hA5);
    rx_enable_i = 1'b1;
  endtask

  task automatic t_overrun();
    rx_char(8'h3C, 1'b0, 1'b0, 1'b0);
    chk("R9 overrun flag", rd_data_o, 8'h62);
    chk("R9 old data kept", rx_data_o, 8'hA5);
  endtask

  task automatic t_errors();
    logic [7:0] d;
    bus_read(d);
    bus_write(8'h00);
    chk("R4 clear RDRF and ORER", rd_data_o, 8'h02);
    rx_char(8'h11, 1'b0, 1'b1, 1'b0);
    chk("R8 parity flag, no RDRF", rd_data_o, 8'h0A);
    chk("R8 parity keeps buffer", rx_data_o, 8'hA5);
    rx_char(8'h12, 1'b0, 1'b0, 1'b1);
    chk("R8 framing flag", rd_data_o, 8'h1A);
    rx_enable_i = 1'b0;
    rx_char(8'h22, 1'b0, 1'b0, 1'b0);
    chk("R8 disabled receiver ignores char", rd_data_o, 8'h1A);
    chk("R8 disabled receiver keeps buffer", rx_data_o, 8'hA5);
    rx_enable_i = 1'b1;
    bus_read(d);
    bus_write(8'h00);
    chk("R4 clear error flags", rd_data_o, 8'h02);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    rx_char(8'h5A, 1'b0, 1'b0, 1'b0);
    tx_load_i = 1'b1; step(); tx_load_i = 1'b0;
    chk("R7 second character", rd_data_o, 8'hC0);
    bus_read(d);
    wr_en_i = 1'b1; wr_data_i = 8'h00; tx_load_i = 1'b1;
    step();
    wr_en_i = 1'b0; tx_load_i = 1'b0;
    chk("R10 set beats clear", rd_data_o, 8'h80);
    bus_write(8'h00);
    chk("R10 no arming left after set", rd_data_o, 8'h80);
    bus_read(d);
    tx_load_i = 1'b1; step(); tx_load_i = 1'b0;
    bus_write(8'h00);
    chk("R4 hw set cancels arming", rd_data_o, 8'h80);
    bus_read(d);
    bus_write(8'h00);
    chk("R4 clear TDRE", rd_data_o, 8'h00);
  endtask

  task automatic t_standby();
    rx_char(8'h99, 1'b0, 1'b0, 1'b0);
    parity_err_i = 1'b1; step(); parity_err_i = 1'b0;
    chk("R8 lone parity pulse", rd_data_o, 8'h48);
    standby_i = 1'b1; step(); standby_i = 1'b0;
    chk("R11 standby flags", rd_data_o, 8'h80);
    chk("R11 standby keeps buffer", rx_data_o, 8'h99);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    tx_enable_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    step();
    t_handshake();
    t_arm_consumed();
    t_tx_disable();
    t_rx_accept();
    t_overrun();
    t_errors();
    t_set_wins();
    t_standby();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule